// File: doc/BRIEF.md
# Pipelined Dual-Product Sum Unit

This block forms the unsigned sum of two products, `(A*B) + (C*D)`. It returns the low 16 bits of that sum and, on a separate output, the carry bit that shows the exact sum reached 65536 or more. All four operands enter through one pair of 8-bit data ports. A select input decides which of the two operand pairs a write goes to. A write enable decides whether anything is written at that edge. Every path from an input port to an output port passes through at least one register.

The two stored pairs feed two multipliers that run side by side. A compile-time parameter can add a register stage between the multipliers and the final adder. This shortens the longest register-to-register path, and the cost is one extra cycle of latency. The same select input also picks which stored pair appears on two registered view outputs, so a system can read back the operands it has loaded.

Top module: `dual_product_sum`

## Requirements
- R1: `sum_out` equals the low 16 bits of `A*B + C*D`, computed from the operand registers. All values are unsigned.
- R2: When `wr_en` is 1 at a rising edge, `data_hi` and `data_lo` are written into the selected pair. With `bank_sel` = 0, `data_hi` goes to A and `data_lo` goes to B. With `bank_sel` = 1, `data_hi` goes to C and `data_lo` goes to D.
- R3: When `wr_en` is 0 at a rising edge, all four operand registers keep their values, whatever is on the data ports and on `bank_sel`.
- R4: With `PIPE_EN` = 1, a write at edge k shows on `sum_out` and `carry_out` after edge k+2. With `PIPE_EN` = 0, it shows after edge k+1.
- R5: After each rising edge, `view_hi` and `view_lo` hold the pair selected by `bank_sel` at that edge: A and B for 0, C and D for 1. The values shown are the ones the pair holds after that edge.
- R6: While `rst_n` is low, all operand, pipeline and output registers are cleared to zero. This happens at once, without waiting for a clock edge.
- R7: `carry_out` is bit 16 of the exact 17-bit sum. A sum of exactly 65536 gives `carry_out` = 1 and `sum_out` = 0. The largest case is 255*255 + 255*255, which gives `carry_out` = 1 and `sum_out` = 0xFC02.
- R8: A write to one pair leaves the other pair unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write enable for the operand pairs |
| bank_sel | input | 1 | Selects the pair: 0 = A/B, 1 = C/D (for both writing and viewing) |
| data_hi | input | DATA_W | Shared data for A or C |
| data_lo | input | DATA_W | Shared data for B or D |
| view_hi | output | DATA_W | Registered view of A or C |
| view_lo | output | DATA_W | Registered view of B or D |
| sum_out | output | 2*DATA_W | Registered low bits of the sum of the two products |
| carry_out | output | 1 | Registered carry of that sum |

## Verification
Two functions can fall in the same cycle. An operand write can land in one pair while the result of an earlier write is still in the product stage or is just reaching `sum_out`. To provoke this, the bench writes on every cycle for a run of cycles, alternating between the pairs, so that each new load overlaps the results still in flight. A scoreboard queues one expected sum per cycle and releases it after the latency of each variant, with the pipelined and the unpipelined instance driven side by side. A single misplaced or shared stage would make one of the two queues disagree.

// File: rtl/dms_pkg.sv
package dms_pkg;

    typedef enum logic {
        BANK_AB = 1'b0,
        BANK_CD = 1'b1
    } bank_e;

    localparam int unsigned NUM_PAIRS = 2;

endpackage

// File: rtl/dms_operand_pair.sv
module dms_operand_pair #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] in_hi,
    input  logic [W-1:0] in_lo,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo,
    output logic [W-1:0] q_hi,
    output logic [W-1:0] q_lo
);

    always_comb begin
        nxt_hi = load ? in_hi : q_hi;
        nxt_lo = load ? in_lo : q_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_hi <= '0;
            q_lo <= '0;
        end else begin
            q_hi <= nxt_hi;
            q_lo <= nxt_lo;
        end
    end

    // R2: a write lands exactly the presented data
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q_hi == $past(in_hi) && q_lo == $past(in_lo)));

    // R3 / R8: without a write the pair keeps its contents
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(q_hi) && $stable(q_lo)));

endmodule

// File: rtl/dms_product.sv
module dms_product #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    always_comb begin
        p = (2*W)'(a) * (2*W)'(b);
    end

endmodule

// File: rtl/dms_stage.sv
module dms_stage #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/dms_sum_reg.sv
module dms_sum_reg #(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] p0,
    input  logic [PW-1:0] p1,
    output logic [PW-1:0] sum_q,
    output logic          carry_q
);

    logic [PW:0] total;

    always_comb begin
        total = {1'b0, p0} + {1'b0, p1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            sum_q   <= total[PW-1:0];
            carry_q <= total[PW];
        end
    end

endmodule

// File: rtl/dual_product_sum.sv
module dual_product_sum
    import dms_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter bit          PIPE_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                bank_sel,
    input  logic [DATA_W-1:0]   data_hi,
    input  logic [DATA_W-1:0]   data_lo,
    output logic [DATA_W-1:0]   view_hi,
    output logic [DATA_W-1:0]   view_lo,
    output logic [2*DATA_W-1:0] sum_out,
    output logic                carry_out
);

    localparam int unsigned PROD_W = 2 * DATA_W;
    localparam int unsigned SUM_W  = PROD_W + 1;

    bank_e sel_bank;
    assign sel_bank = bank_e'(bank_sel);

    logic [DATA_W-1:0] hi_q [NUM_PAIRS];
    logic [DATA_W-1:0] lo_q [NUM_PAIRS];
    logic [DATA_W-1:0] hi_n [NUM_PAIRS];
    logic [DATA_W-1:0] lo_n [NUM_PAIRS];
    logic [PROD_W-1:0] prod   [NUM_PAIRS];
    logic [PROD_W-1:0] prod_s [NUM_PAIRS];

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic load_g;
        assign load_g = wr_en && (sel_bank == bank_e'(g[0]));

        dms_operand_pair #(.W(DATA_W)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load_g),
            .in_hi  (data_hi),
            .in_lo  (data_lo),
            .nxt_hi (hi_n[g]),
            .nxt_lo (lo_n[g]),
            .q_hi   (hi_q[g]),
            .q_lo   (lo_q[g])
        );

        dms_product #(.W(DATA_W)) u_mul (
            .a (hi_q[g]),
            .b (lo_q[g]),
            .p (prod[g])
        );

        if (PIPE_EN) begin : g_pipe
            dms_stage #(.WIDTH(PROD_W)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (prod[g]),
                .q     (prod_s[g])
            );
        end else begin : g_flat
            assign prod_s[g] = prod[g];
        end
    end

    dms_sum_reg #(.PW(PROD_W)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .p0      (prod_s[0]),
        .p1      (prod_s[1]),
        .sum_q   (sum_out),
        .carry_q (carry_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            view_hi <= '0;
            view_lo <= '0;
        end else begin
            unique case (sel_bank)
                BANK_AB: begin
                    view_hi <= hi_n[0];
                    view_lo <= lo_n[0];
                end
                BANK_CD: begin
                    view_hi <= hi_n[1];
                    view_lo <= lo_n[1];
                end
                default: begin
                    view_hi <= hi_n[0];
                    view_lo <= lo_n[0];
                end
            endcase
        end
    end

    // Checker-side exact sum taken directly from the operand registers
    logic [SUM_W-1:0] exact_now;
    assign exact_now = SUM_W'(hi_q[0]) * SUM_W'(lo_q[0])
                     + SUM_W'(hi_q[1]) * SUM_W'(lo_q[1]);

    // R1 / R4 / R7: output equals the exact sum, delayed by the stage count
    if (PIPE_EN) begin : g_chk_pipe
        p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
            {carry_out, sum_out} == $past(exact_now, 2));
    end else begin : g_chk_flat
        p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
            {carry_out, sum_out} == $past(exact_now, 1));
    end

    // R5: view shows the pair chosen at the previous edge, current contents
    p_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
        {view_hi, view_lo} == ($past(bank_sel) ? {hi_q[1], lo_q[1]}
                                               : {hi_q[0], lo_q[0]}));

    // R6: registers sit at zero while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r6: assert (sum_out == '0 && !carry_out
                                && view_hi == '0 && view_lo == '0);
        end
    end

endmodule

// File: tb/dual_product_sum_tb.sv
`timescale 1ns/1ps
module dual_product_sum_tb;

    localparam int unsigned DW    = 8;
    localparam int unsigned LAT_P = 2;
    localparam int unsigned LAT_F = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          bank_sel = 1'b0;
    logic [DW-1:0] data_hi = '0;
    logic [DW-1:0] data_lo = '0;

    logic [DW-1:0]   vh_p, vl_p, vh_f, vl_f;
    logic [2*DW-1:0] s_p, s_f;
    logic            c_p, c_f;

    always #2.5 clk = ~clk;

    dual_product_sum #(.DATA_W(DW), .PIPE_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bank_sel(bank_sel),
        .data_hi(data_hi), .data_lo(data_lo),
        .view_hi(vh_p), .view_lo(vl_p), .sum_out(s_p), .carry_out(c_p)
    );

    dual_product_sum #(.DATA_W(DW), .PIPE_EN(1'b0)) u_dut_flat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bank_sel(bank_sel),
        .data_hi(data_hi), .data_lo(data_lo),
        .view_hi(vh_f), .view_lo(vl_f), .sum_out(s_f), .carry_out(c_f)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [16:0] q_pipe [$];
    logic [16:0] q_flat [$];

    logic [DW-1:0] m_hi [2];
    logic [DW-1:0] m_lo [2];
    logic [15:0]   exp_view;
    bit            have_view = 1'b0;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] model_sum();
        return 17'(m_hi[0]) * 17'(m_lo[0]) + 17'(m_hi[1]) * 17'(m_lo[1]);
    endfunction

    // Driver: one call per cycle; pushes the expected result for both variants
    task automatic step(input bit wr, input bit sel,
                        input logic [DW-1:0] hi, input logic [DW-1:0] lo);
        @(negedge clk);
        if (have_view) begin
            check("R5 view pipelined", {vh_p, vl_p}, exp_view);
            check("R5 view flat",      {vh_f, vl_f}, exp_view);
        end
        wr_en = wr; bank_sel = sel; data_hi = hi; data_lo = lo;
        if (wr) begin
            m_hi[sel] = hi;
            m_lo[sel] = lo;
        end
        exp_view  = {m_hi[sel], m_lo[sel]};
        have_view = 1'b1;
        q_pipe.push_back(model_sum());
        q_flat.push_back(model_sum());
    endtask

    // Monitor: releases each expectation after the latency of its variant
    always begin
        @(negedge clk);
        #1;
        if (q_pipe.size() == LAT_P + 2) begin
            logic [16:0] e;
            e = q_pipe.pop_front();
            check(e[16] ? "R1 R4 R7 pipelined" : "R1 R4 pipelined",
                  {c_p, s_p}, e);
        end
        if (q_flat.size() == LAT_F + 2) begin
            logic [16:0] e;
            e = q_flat.pop_front();
            check(e[16] ? "R1 R4 R7 flat" : "R1 R4 flat", {c_f, s_f}, e);
        end
    end

    task automatic reset_checks(input string tag);
        check({tag, " R6 sum pipelined"},  {c_p, s_p}, 0);
        check({tag, " R6 sum flat"},       {c_f, s_f}, 0);
        check({tag, " R6 view pipelined"}, {vh_p, vl_p}, 0);
        check({tag, " R6 view flat"},      {vh_f, vl_f}, 0);
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 2; i++) begin
            m_hi[i] = '0;
            m_lo[i] = '0;
        end
        repeat (3) @(negedge clk);
        reset_checks("initial");
        rst_n = 1'b1;

        // R2: load A/B, then C/D
        step(1'b1, 1'b0, 8'd3, 8'd5);
        step(1'b1, 1'b1, 8'd7, 8'd11);
        // R3 / R8: no write, data ports toggled, both selects viewed
        step(1'b0, 1'b0, 8'd200, 8'd200);
        step(1'b0, 1'b1, 8'd99, 8'd1);
        step(1'b0, 1'b0, 8'd0, 8'd0);
        // R7: largest case, then exact 65536 boundary, then just below
        step(1'b1, 1'b0, 8'd255, 8'd255);
        step(1'b1, 1'b1, 8'd255, 8'd255);
        step(1'b1, 1'b1, 8'd7, 8'd73);
        step(1'b1, 1'b1, 8'd7, 8'd72);
        step(1'b1, 1'b1, 8'd0, 8'd1);
        // R4: writes every cycle, alternating pairs, overlapping in-flight results
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step((i % 5) != 4, i[0], lfsr[15:8], lfsr[7:0]);
        end
        // Drain pipelines
        for (int i = 0; i < 5; i++) step(1'b0, i[0], 8'hFF, 8'hFF);

        // R6: asynchronous reset in mid-cycle
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        reset_checks("async");
        q_pipe.delete();
        q_flat.delete();
        have_view = 1'b0;
        for (int i = 0; i < 2; i++) begin
            m_hi[i] = '0;
            m_lo[i] = '0;
        end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 8'd16, 8'd16);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 8'd1, 8'd2);
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule